// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures how long an external pulse stays high. Each input pin has its own capture channel. A channel holds a saturating counter that advances once per prescaled tick, one tick every four system clocks, while the synchronized input is high. When the pulse ends, the channel sets a sticky request bit. The request drives the channel's interrupt line, and a host that prefers not to take an interrupt can poll the same bit. The host then reads the captured count and clears it so the channel is ready for the next pulse.

If a pulse outlasts the counter's range, the count stops at its all-ones value and a sticky limit flag is set. The limit flag raises the interrupt line only when its enable bit is set. Both channels share one flat register space. Each channel has a count register and a status/control register, and each register is reached by a single-cycle write strobe or a combinational read.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset every count reads 0, every status register reads 0 and every `irq_o` bit is 0.
- R2: A pulse held high on `pulse_i[c]` for L consecutive clocks leaves count c at floor(L/4), provided that value stays below the limit. The count then holds unchanged until the host clears it.
- R3: The count saturates at 2^CNT_W-1 and never wraps to zero, however long the pulse lasts.
- R4: Status bit 1 (limit flag) is set in the cycle the count reaches 2^CNT_W-1 and is not set by a pulse that ends short of it.
- R5: Status bit 0 (request) is set by the end of a pulse, which is the falling edge of the synchronized input. A rising edge or a held-high level does not set it.
- R6: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 to either bit leaves it unchanged.
- R7: Any write to a channel's count register clears that count to 0.
- R8: `irq_o[c]` is the request bit of channel c, OR'ed with the AND of its limit flag and its enable bit. The enable bit is status bit 2, which is read/write.
- R9: A pulse on one input changes only the count and flags of its own channel.
- R10: Address 2c selects count register c and address 2c+1 selects status register c. Reads are combinational and unused upper data bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | NUM_CH | Pulse inputs, one per channel, active high, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | $clog2(2*NUM_CH) | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The input passes through two synchronizer flops. The count therefore stops changing two clocks after the pin falls, and the request bit rises on the third clock. Host writes act on the next clock edge, and reads follow `addr_i` within the same cycle. The bench drives every pulse on falling clock edges for an exact number of cycles. It then idles six cycles before it reads anything back, so every check samples settled state away from the edges. Limit behaviour is swept with a 6-bit counter, so saturation is reached in a few hundred cycles.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int STS_REQ_BIT = 0;
  localparam int STS_MAX_BIT = 1;
  localparam int STS_IE_BIT  = 2;

  typedef enum logic {
    REG_CNT = 1'b0,
    REG_STS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pwt_sync.sv
module pwt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/pwt_prescale.sv
module pwt_prescale #(
  parameter int PRESC = 4,
  localparam int PW = (PRESC > 2) ? $clog2(PRESC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);
  logic [PW-1:0] psc_q;

  // restarts with each pulse so the count depends only on pulse length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             psc_q <= '0;
    else if (!en_i)          psc_q <= '0;
    else if (psc_q == LAST)  psc_q <= '0;
    else                     psc_q <= psc_q + 1'b1;
  end

  assign tick_o = en_i && (psc_q == LAST);
endmodule

// File: rtl/pwt_channel.sv
module pwt_channel #(
  parameter int CNT_W = 16,
  parameter int PRESC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             clr_cnt_i,
  input  logic             sts_we_i,
  input  logic [2:0]       sts_wd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o,
  output logic             max_o,
  output logic             ie_o,
  output logic             irq_o
);
  import pwt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic lvl, fall, tick, hit_max;
  logic [CNT_W-1:0] cnt_q;
  logic req_q, max_q, ie_q;

  pwt_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .fall_o(fall)
  );

  pwt_prescale #(.PRESC(PRESC)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (lvl),
    .tick_o(tick)
  );

  assign hit_max = tick && !clr_cnt_i && (cnt_q == CNT_MAX - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_cnt_i)                 cnt_q <= '0;
    else if (tick && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  // set wins over a same-cycle write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      max_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (fall)                                 req_q <= 1'b1;
      else if (sts_we_i && sts_wd_i[STS_REQ_BIT]) req_q <= 1'b0;
      if (hit_max)                              max_q <= 1'b1;
      else if (sts_we_i && sts_wd_i[STS_MAX_BIT]) max_q <= 1'b0;
      if (sts_we_i)                             ie_q  <= sts_wd_i[STS_IE_BIT];
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
  assign max_o = max_q;
  assign ie_o  = ie_q;
  assign irq_o = req_q | (max_q & ie_q);
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PRESC  = 4,
  parameter int DW     = 16,
  localparam int AW    = $clog2(2 * NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  import pwt_pkg::*;

  localparam int IW = AW - 1;

  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_CH-1:0] req_w, max_w, ie_w, clr_w, sts_we_w;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign clr_w[g]    = wr_i && (addr_i == AW'(2 * g));
    assign sts_we_w[g] = wr_i && (addr_i == AW'(2 * g + 1));

    pwt_channel #(.CNT_W(CNT_W), .PRESC(PRESC)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pulse_i[g]),
      .clr_cnt_i(clr_w[g]),
      .sts_we_i (sts_we_w[g]),
      .sts_wd_i (wdata_i[2:0]),
      .cnt_o    (cnt_w[g]),
      .req_o    (req_w[g]),
      .max_o    (max_w[g]),
      .ie_o     (ie_w[g]),
      .irq_o    (irq_o[g])
    );
  end

  logic [IW-1:0] ch_idx;
  reg_sel_e      sel;

  assign ch_idx = addr_i[AW-1:1];
  assign sel    = reg_sel_e'(addr_i[0]);

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == IW'(c)) begin
        if (sel == REG_CNT) begin
          rdata_o[CNT_W-1:0] = cnt_w[c];
        end else begin
          rdata_o[STS_REQ_BIT] = req_w[c];
          rdata_o[STS_MAX_BIT] = max_w[c];
          rdata_o[STS_IE_BIT]  = ie_w[c];
        end
      end
    end
  end
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            req,
  input logic [NUM_CH-1:0]            maxf,
  input logic [NUM_CH-1:0]            ie,
  input logic [NUM_CH-1:0]            clr,
  input logic [NUM_CH-1:0]            irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr[g] |=> (cnt[g] == $past(cnt[g]) || cnt[g] == CNT_W'($past(cnt[g]) + 1'b1))); // R2
    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt[g] == CNT_MAX && !clr[g]) |=> cnt[g] == CNT_MAX); // R3
    AST_MAX_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(maxf[g]) |-> cnt[g] == CNT_MAX); // R4
    AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[g] |=> cnt[g] == '0); // R7
    AST_IRQ_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (maxf[g] && ie[g]) |-> irq_o[g]); // R8
    AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req[g] && !maxf[g]) |-> !irq_o[g]); // R8
  end
endmodule

bind pulse_width_timer pwt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pwt_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt   (cnt_w),
  .req   (req_w),
  .maxf  (max_w),
  .ie    (ie_w),
  .clr   (clr_w),
  .irq_o (irq_o)
);

// File: tb/pulse_width_timer_bench.sv
`timescale 1ns/1ps
module pulse_width_timer_bench;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 6;
  localparam int PRESC  = 4;
  localparam int DW     = 16;
  localparam int AW     = 2;
  localparam int MAXV   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_CH-1:0] pulse = '0;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pulse_width_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRESC(PRESC), .DW(DW)) u_pulse_width_timer (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .pulse_i(pulse),
    .wr_i   (wr),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = AW'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic wrr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulses(input int l0, input int l1);
    int lm;
    lm = (l0 > l1) ? l0 : l1;
    for (int i = 0; i < lm; i++) begin
      @(negedge clk);
      pulse[0] = (i < l0);
      pulse[1] = (i < l1);
    end
    @(negedge clk);
    pulse = '0;
    repeat (6) @(negedge clk);
  endtask

  function automatic int expc(input int l);
    return (l / PRESC > MAXV) ? MAXV : l / PRESC;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state, R10 map
    for (int a = 0; a < 4; a++) begin
      rd(a, v); chk("R1", v, 0);
    end
    chk("R1 irq", int'(irq), 0);

    // R2/R5 sweep of lengths on channel 0
    for (int l = 0; l <= 40; l++) begin
      wrr(0, 0); wrr(1, 3);
      pulses(l, 0);
      rd(0, v); chk("R2 count", v, expc(l));
      rd(1, v); chk("R5 req", v & 1, (l > 0) ? 1 : 0);
      chk("R8 irq req", int'(irq[0]), (l > 0) ? 1 : 0);
    end

    // R2 hold after pulse end
    rd(0, v); repeat (10) @(negedge clk); rd(0, v2);
    chk("R2 hold", v2, v);

    // R5 rising edge and held level do not set request
    wrr(1, 3); wrr(0, 0);
    @(negedge clk); pulse[0] = 1'b1;
    repeat (20) @(negedge clk);
    rd(1, v); chk("R5 no req while high", v & 1, 0);
    @(negedge clk); pulse[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(1, v); chk("R5 req after fall", v & 1, 1);

    // R6 write zero keeps, write one clears
    wrr(1, 0); rd(1, v); chk("R6 w0 keeps", v & 1, 1);
    wrr(1, 1); rd(1, v); chk("R6 w1 clears", v & 1, 0);

    // R4 just short of and exactly at limit
    wrr(0, 0); wrr(1, 3);
    pulses(PRESC * MAXV - 1, 0);
    rd(0, v); chk("R4 short count", v, MAXV - 1);
    rd(1, v); chk("R4 short flag", (v >> 1) & 1, 0);
    wrr(0, 0); wrr(1, 3);
    pulses(PRESC * MAXV, 0);
    rd(0, v); chk("R4 exact count", v, MAXV);
    rd(1, v); chk("R4 exact flag", (v >> 1) & 1, 1);

    // R3 saturation
    wrr(0, 0); wrr(1, 3);
    pulses(PRESC * MAXV + 60, 0);
    rd(0, v); chk("R3 saturate", v, MAXV);

    // R8 enable gating of limit flag
    wrr(1, 1);
    chk("R8 irq masked", int'(irq[0]), 0);
    wrr(1, 4);
    rd(1, v); chk("R8 ie readback", v, 6);
    chk("R8 irq enabled", int'(irq[0]), 1);
    wrr(1, 6);
    rd(1, v); chk("R6 max cleared", v, 4);
    chk("R8 irq after clear", int'(irq[0]), 0);

    // R7 clear count
    wrr(0, 0); rd(0, v); chk("R7 clear", v, 0);

    // R9 independence and concurrent pulses
    pulses(0, 20);
    rd(2, v); chk("R9 ch1 count", v, 5);
    rd(0, v); chk("R9 ch0 untouched", v, 0);
    rd(1, v); chk("R9 ch0 req untouched", v & 1, 0);
    chk("R9 irq vector", int'(irq), 2);
    wrr(2, 0); wrr(3, 3);
    pulses(13, 37);
    rd(0, v); chk("R9 ch0 concurrent", v, 3);
    rd(2, v); chk("R9 ch1 concurrent", v, 9);
    wrr(2, 0); rd(2, v); chk("R7 ch1 clear", v, 0);
    rd(0, v); chk("R7 ch0 kept", v, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule